// File: doc/BRIEF.md
# FIFO Threshold DMA Request Logic

This block holds a receive FIFO, which a serial engine fills, and a transmit FIFO, which a serial engine drains. It raises a DMA request line for each direction by comparing the live FIFO occupancy against a programmed threshold. The receive request is raised while there are more entries than the receive threshold. The transmit request is raised while there are fewer entries than the transmit threshold.

The DMA controller can service a request in either of two ways. It can make an ordinary chip-selected bus access to the data port, where a read takes the oldest receive entry and a write stores into the transmit FIFO. It can also pulse a dedicated acknowledge strobe, which moves a word directly without chip select. A configuration enable per direction decides whether that direction's acknowledge strobe is honoured. If a read finds its FIFO empty, or a write finds its FIFO full, the word is discarded and a sticky error flag is set.

Top module: `fdr_dma_req`

## Requirements
- R1: After a synchronous active-low reset, both levels are 0, `rx_req` is 0, all four error flags are 0, and `tx_req` equals (0 < `tx_thr`).
- R2: `rx_req` is 1 exactly when `rx_level` > `rx_thr`. Because it is computed from the current level, it follows a level change in the same cycle that the level updates.
- R3: `tx_req` is 1 exactly when `tx_level` < `tx_thr`. It also follows a level change in the same cycle that the level updates.
- R4: A cycle with `bus_cs`=1 and `bus_rd`=1 pops the receive FIFO. `bus_rdata` always shows the oldest receive entry, so data leaves in arrival order.
- R5: With `rx_ack_en`=1, a cycle with `rx_ack`=1 pops the receive FIFO without chip select. The popped word is on `bus_rdata` during that cycle.
- R6: A cycle with `bus_cs`=1 and `bus_wr`=1 pushes `bus_wdata` into the transmit FIFO. So does a cycle with `tx_ack_en`=1 and `tx_ack`=1, with no chip select needed. `tx_pop_data` shows the oldest transmit entry.
- R7: When its enable is 0, an acknowledge strobe is ignored and leaves the FIFO level unchanged.
- R8: A push into a full FIFO (32 entries) is discarded, leaves the level at 32, and sets that FIFO's sticky overflow flag (`rx_ovf` or `tx_ovf`).
- R9: A pop from an empty FIFO leaves the level at 0 and sets that FIFO's sticky underflow flag (`rx_unf` or `tx_unf`). The flag holds until reset.
- R10: `bus_rd` or `bus_wr` without `bus_cs` has no effect on either FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_push | input | 1 | Serial engine writes a received word |
| rx_push_data | input | DW | Received word |
| tx_pop | input | 1 | Serial engine takes a word to send |
| tx_pop_data | output | DW | Oldest transmit entry |
| bus_cs | input | 1 | Chip select for the data port |
| bus_rd | input | 1 | Read strobe (receive FIFO) |
| bus_wr | input | 1 | Write strobe (transmit FIFO) |
| bus_wdata | input | DW | Write data, also used by the transmit acknowledge |
| bus_rdata | output | DW | Oldest receive entry |
| rx_ack | input | 1 | Receive fly-by acknowledge strobe |
| tx_ack | input | 1 | Transmit fly-by acknowledge strobe |
| rx_ack_en | input | 1 | Enables the receive acknowledge strobe |
| tx_ack_en | input | 1 | Enables the transmit acknowledge strobe |
| rx_thr | input | TW | Receive threshold |
| tx_thr | input | TW | Transmit threshold |
| rx_req | output | 1 | Receive DMA request |
| tx_req | output | 1 | Transmit DMA request |
| rx_level | output | LW | Receive FIFO occupancy |
| tx_level | output | LW | Transmit FIFO occupancy |
| rx_ovf | output | 1 | Sticky receive overflow |
| rx_unf | output | 1 | Sticky receive underflow |
| tx_ovf | output | 1 | Sticky transmit overflow |
| tx_unf | output | 1 | Sticky transmit underflow |

## Verification
A push, pop or strobe is taken at one clock edge. The levels, error flags and both requests show the result right after that edge, because each request is combinational from its level register. The head data (`bus_rdata`, `tx_pop_data`) is valid in the same cycle as the strobe that consumes it. The bench therefore drives stimulus just after a falling edge and reads the head data before the next rising edge. It reads the levels, flags and requests at the falling edge that follows, which is exactly one rising edge after the stimulus.

// File: rtl/fdr_pkg.sv
// Shared types for the FIFO threshold DMA request block.
package fdr_pkg;
    // Direction of the threshold comparison.
    typedef enum logic {
        CMP_ABOVE = 1'b0,   // request while level exceeds threshold
        CMP_BELOW = 1'b1    // request while level is under threshold
    } cmp_mode_e;
endpackage

// File: rtl/fdr_fifo.sv
// Synchronous FIFO with an occupancy counter and sticky overflow and underflow flags.
// Assumes DEPTH is a power of two, so the pointers wrap naturally.
// A push into a full FIFO or a pop from an empty FIFO is dropped and flagged.
// The head entry is shown combinationally (show-ahead).
module fdr_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [LW-1:0] level,
    output logic          ovf,
    output logic          unf
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          full, empty, push_ok, pop_ok;

    // Decode occupancy state and the accepted operations.
    always_comb begin
        full    = (level == LW'(DEPTH));
        empty   = (level == '0);
        push_ok = push && !full;
        pop_ok  = pop && !empty;
    end

    // Storage write; the data array needs no reset.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wp] <= push_data;
    end

    // Pointer, level and sticky flag update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
            ovf   <= 1'b0;
            unf   <= 1'b0;
        end else begin
            if (push_ok) wp <= wp + AW'(1);
            if (pop_ok)  rp <= rp + AW'(1);
            if (push_ok && !pop_ok)      level <= level + LW'(1);
            else if (!push_ok && pop_ok) level <= level - LW'(1);
            if (push && full)  ovf <= 1'b1;
            if (pop && empty)  unf <= 1'b1;
        end
    end

    assign head = mem[rp];

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH)); // R8
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (level == LW'(DEPTH))); // R8
    AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> (level == '0)); // R9
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf); // R8
    AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        unf |=> unf); // R9
endmodule

// File: rtl/fdr_thr_cmp.sv
// Threshold comparator that turns a FIFO level into a DMA request.
// MODE picks the sense of the comparison: above for receive, below for transmit.
// The output is purely combinational, so it tracks the level register directly.
module fdr_thr_cmp
    import fdr_pkg::*;
#(
    parameter int        LW   = 6,
    parameter int        TW   = 5,
    parameter cmp_mode_e MODE = CMP_ABOVE
) (
    input  logic [LW-1:0] level,
    input  logic [TW-1:0] thr,
    output logic          req
);
    generate
        if (MODE == CMP_ABOVE) begin : g_above
            // Request while occupancy exceeds the threshold.
            always_comb req = (level > LW'(thr));
        end else begin : g_below
            // Request while occupancy is under the threshold.
            always_comb req = (level < LW'(thr));
        end
    endgenerate
endmodule

// File: rtl/fdr_dma_req.sv
// FIFO threshold DMA request block: receive and transmit FIFOs, a threshold request per
// direction, and FIFO access through either a chip-selected bus cycle or a fly-by
// acknowledge strobe. Assumes at most one consumer and one producer per FIFO per cycle.
// A bus access and an enabled strobe in the same cycle act as a single access.
module fdr_dma_req
    import fdr_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 32,
    parameter int TW    = 5,
    localparam int LW   = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_push,
    input  logic [DW-1:0] rx_push_data,
    input  logic          tx_pop,
    output logic [DW-1:0] tx_pop_data,
    input  logic          bus_cs,
    input  logic          bus_rd,
    input  logic          bus_wr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          rx_ack,
    input  logic          tx_ack,
    input  logic          rx_ack_en,
    input  logic          tx_ack_en,
    input  logic [TW-1:0] rx_thr,
    input  logic [TW-1:0] tx_thr,
    output logic          rx_req,
    output logic          tx_req,
    output logic [LW-1:0] rx_level,
    output logic [LW-1:0] tx_level,
    output logic          rx_ovf,
    output logic          rx_unf,
    output logic          tx_ovf,
    output logic          tx_unf
);
    logic rx_take, tx_give;

    // Merge the bus cycle and the gated fly-by strobe into one access per FIFO.
    always_comb begin
        rx_take = (bus_cs && bus_rd) || (rx_ack && rx_ack_en);
        tx_give = (bus_cs && bus_wr) || (tx_ack && tx_ack_en);
    end

    fdr_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(rx_push), .push_data(rx_push_data),
        .pop(rx_take), .head(bus_rdata),
        .level(rx_level), .ovf(rx_ovf), .unf(rx_unf)
    );

    fdr_fifo #(.DW(DW), .DEPTH(DEPTH)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(tx_give), .push_data(bus_wdata),
        .pop(tx_pop), .head(tx_pop_data),
        .level(tx_level), .ovf(tx_ovf), .unf(tx_unf)
    );

    fdr_thr_cmp #(.LW(LW), .TW(TW), .MODE(CMP_ABOVE)) u_rx_cmp (
        .level(rx_level), .thr(rx_thr), .req(rx_req)
    );

    fdr_thr_cmp #(.LW(LW), .TW(TW), .MODE(CMP_BELOW)) u_tx_cmp (
        .level(tx_level), .thr(tx_thr), .req(tx_req)
    );

    AST_RX_REQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_req) |-> (rx_level != $past(rx_level) || rx_thr != $past(rx_thr))); // R2
    AST_TX_REQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_req) |-> (tx_level != $past(tx_level) || tx_thr != $past(tx_thr))); // R3
    AST_RX_ACK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ack && !rx_ack_en && !bus_cs && !rx_push) |=> $stable(rx_level)); // R7
    AST_TX_ACK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ack && !tx_ack_en && !bus_cs && !tx_pop) |=> $stable(tx_level)); // R7
    AST_NO_CS_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_cs && !rx_ack && !rx_push) |=> $stable(rx_level)); // R10
endmodule

// File: tb/tb_fdr_dma_req.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_fdr_dma_req;
    localparam int DW = 8;
    localparam int LW = 6;
    localparam int TW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_push = 0, tx_pop = 0, bus_cs = 0, bus_rd = 0, bus_wr = 0;
    logic          rx_ack = 0, tx_ack = 0, rx_ack_en = 0, tx_ack_en = 0;
    logic [DW-1:0] rx_push_data = '0, bus_wdata = '0;
    logic [TW-1:0] rx_thr = 5'd4, tx_thr = 5'd8;
    logic [DW-1:0] tx_pop_data, bus_rdata;
    logic          rx_req, tx_req, rx_ovf, rx_unf, tx_ovf, tx_unf;
    logic [LW-1:0] rx_level, tx_level;

    int nchk = 0;
    int nfail = 0;

    always #5 clk = ~clk;

    fdr_dma_req dut (
        .clk(clk), .rst_n(rst_n),
        .rx_push(rx_push), .rx_push_data(rx_push_data),
        .tx_pop(tx_pop), .tx_pop_data(tx_pop_data),
        .bus_cs(bus_cs), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_ack(rx_ack), .tx_ack(tx_ack),
        .rx_ack_en(rx_ack_en), .tx_ack_en(tx_ack_en),
        .rx_thr(rx_thr), .tx_thr(tx_thr),
        .rx_req(rx_req), .tx_req(tx_req),
        .rx_level(rx_level), .tx_level(tx_level),
        .rx_ovf(rx_ovf), .rx_unf(rx_unf), .tx_ovf(tx_ovf), .tx_unf(tx_unf)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step(); step();
        rst_n = 1'b1;
        step();
        chk("R1 rx_level", rx_level, 0);
        chk("R1 tx_level", tx_level, 0);
        chk("R1 rx_req", rx_req, 0);
        chk("R1 tx_req", tx_req, 1);
        chk("R1 flags", {rx_ovf, rx_unf, tx_ovf, tx_unf}, 0);
    endtask

    task automatic t_rx_threshold();
        rx_push = 1;
        for (int i = 0; i < 4; i++) begin
            rx_push_data = 8'h10 + 8'(i);
            step();
        end
        rx_push = 0;
        chk("R2 level 4 no req", rx_req, 0);
        rx_push = 1; rx_push_data = 8'h14;
        step();
        rx_push = 0;
        chk("R2 level", rx_level, 5);
        chk("R2 req above thr", rx_req, 1);
        bus_cs = 1; bus_rd = 1;
        chk("R4 head data", bus_rdata, 8'h10);
        step();
        bus_cs = 0; bus_rd = 0;
        chk("R4 level after read", rx_level, 4);
        chk("R2 req drops", rx_req, 0);
    endtask

    task automatic t_rx_ack();
        rx_ack = 1;
        step();
        rx_ack = 0;
        chk("R7 rx ack disabled", rx_level, 4);
        bus_rd = 1;
        step();
        bus_rd = 0;
        chk("R10 read without cs", rx_level, 4);
        rx_ack_en = 1; rx_ack = 1;
        chk("R5 fly-by data", bus_rdata, 8'h11);
        step();
        rx_ack = 0; rx_ack_en = 0;
        chk("R5 fly-by level", rx_level, 3);
        bus_cs = 1; bus_rd = 1;
        for (int i = 0; i < 3; i++) begin
            chk("R4 order", bus_rdata, 8'h12 + i);
            step();
        end
        chk("R9 no unf yet", rx_unf, 0);
        step();
        bus_cs = 0; bus_rd = 0;
        chk("R9 rx_unf set", rx_unf, 1);
        chk("R9 level stays 0", rx_level, 0);
        step();
        chk("R9 rx_unf sticky", rx_unf, 1);
    endtask

    task automatic t_tx();
        bus_cs = 1; bus_wr = 1;
        for (int i = 0; i < 7; i++) begin
            bus_wdata = 8'hA0 + 8'(i);
            step();
        end
        bus_cs = 0; bus_wr = 0;
        chk("R3 level 7", tx_level, 7);
        chk("R3 req below thr", tx_req, 1);
        tx_ack_en = 1; tx_ack = 1; bus_wdata = 8'hA7;
        step();
        tx_ack = 0; tx_ack_en = 0;
        chk("R6 fly-by write", tx_level, 8);
        chk("R3 req drops at thr", tx_req, 0);
        tx_ack = 1;
        step();
        tx_ack = 0;
        chk("R7 tx ack disabled", tx_level, 8);
        bus_wr = 1;
        step();
        bus_wr = 0;
        chk("R10 write without cs", tx_level, 8);
        tx_pop = 1;
        chk("R6 tx head", tx_pop_data, 8'hA0);
        step();
        tx_pop = 0;
        chk("R3 req returns", tx_req, 1);
        bus_cs = 1; bus_wr = 1;
        for (int i = 0; i < 25; i++) begin
            bus_wdata = 8'hA8 + 8'(i);
            step();
        end
        chk("R8 full level", tx_level, 32);
        chk("R8 no ovf yet", tx_ovf, 0);
        bus_wdata = 8'hEE;
        step();
        bus_cs = 0; bus_wr = 0;
        chk("R8 tx_ovf set", tx_ovf, 1);
        chk("R8 level held", tx_level, 32);
        tx_pop = 1;
        for (int i = 0; i < 32; i++) begin
            chk("R6 tx order", tx_pop_data, 8'hA1 + i);
            step();
        end
        step();
        tx_pop = 0;
        chk("R9 tx_unf set", tx_unf, 1);
        chk("R9 tx level 0", tx_level, 0);
    endtask

    task automatic t_rx_ovf();
        rx_push = 1;
        for (int i = 0; i < 33; i++) begin
            rx_push_data = 8'(i);
            step();
        end
        rx_push = 0;
        chk("R8 rx_ovf set", rx_ovf, 1);
        chk("R8 rx level 32", rx_level, 32);
        chk("R2 req when full", rx_req, 1);
        rx_thr = 5'd31;
        #1;
        chk("R2 thr 31 still req", rx_req, 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end

    initial begin
        t_reset();
        t_rx_threshold();
        t_rx_ack();
        t_tx();
        t_rx_ovf();
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end
endmodule